// File: doc/BRIEF.md
# Idle-Strobe Power-Down Controller

This block sits beside a programmable memory-and-logic peripheral on a microcontroller bus and decides when that peripheral may drop into low-power operation. It watches the bus address strobe. When the strobe has stayed at a programmed idle level, with no transitions, for a fixed number of system clocks, the block raises a power-down output. Any movement of the strobe brings the output back down and starts the wait over.

The block also does three gating jobs. A chip-select input switches the memory enables on or off without touching the logic-side signals. One configuration register can cut the peripheral's logic clock away from the logic array and from the output registers, each on its own. A second register can force each control input bound for the logic array to an inactive 0, one at a time. All configuration sits in a small register window that is written through an address/data/write-strobe port and read back through the same address.

Top module: `idle_pwrdn_ctrl`

## Requirements
- R1: After reset, every register in the window reads 0 and `pwrdn_o` is 0.
- R2: While the idle-enable bit (bit 0 of the register at address 1) is 0, `pwrdn_o` stays 0 whatever the strobe does.
- R3: With idle-enable set, a clock edge counts when the strobe equals the idle-level bit (bit 1 of address 1) and has not changed since the previous edge. `pwrdn_o` rises after the 15th consecutive counted edge, for idle level 1 and for idle level 0.
- R4: With idle-enable set, a change of the strobe, or a strobe level that differs from the idle level, clears the count. A strobe that toggles more often than every 15 clocks never raises `pwrdn_o`.
- R5: Once raised, `pwrdn_o` stays high while the strobe stays at the idle level. It falls on the edge after any strobe change, or after idle-enable is cleared.
- R6: Every bit of `mem_en_o` is 1 while `cs_n_i` is 0 and 0 while it is 1. Chip select has no effect on the gated logic signals or on `pwrdn_o`.
- R7: Bit 4 of address 0 turns off `arr_clk_o`, and bit 5 turns off `mcell_clk_o`. A gated clock that is off stays at 0. A gated clock that is on follows `pld_clk_i`. A change of either bit takes effect only while `pld_clk_i` is low, so no clock high phase is ever cut short.
- R8: Bits 2 to 6 of address 2 force to 0, in this order, the array copies of control inputs 0, 1 and 2, of the strobe and of the byte enable. A copy whose bit is clear equals its input.
- R9: Addresses 0 to 2 hold all 8 written bits and read them back unchanged on `reg_rdata_o` for the current `reg_addr_i`. Address 3 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Bus address strobe |
| cs_n_i | input | 1 | Active-low chip select for the memory blocks |
| ctl_i | input | 3 | Control inputs bound for the logic array |
| byte_en_i | input | 1 | Byte-enable input bound for the logic array |
| pld_clk_i | input | 1 | Logic-side clock input to be gated |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for write and read |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| pwrdn_o | output | 1 | Power-down request |
| mem_en_o | output | 3 | Memory block enables |
| arr_clk_o | output | 1 | Gated clock to the logic array |
| mcell_clk_o | output | 1 | Gated clock to the output registers |
| arr_ctl_o | output | 3 | Gated control inputs |
| arr_strobe_o | output | 1 | Gated strobe |
| arr_byte_en_o | output | 1 | Gated byte enable |

## Verification
The idle detector is driven in several ways. The strobe is held steady with counting disabled, which separates the enable gate from the counter. It is held at each idle level long enough to saturate, which fixes the exact edge at which power-down rises for both polarities. A single one-clock glitch is applied while saturated, which tells an edge-triggered clear from a level-only one. Steady toggling is applied at a period below the limit, which shows that no count builds up across pulses. The clock gates are tried while the source clock runs and the disable bits change mid-phase, to show that changes are deferred to the low phase.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int NUM_REGS = 3;

  // register window
  localparam int ADDR_CLK  = 0;
  localparam int ADDR_IDLE = 1;
  localparam int ADDR_CTL  = 2;

  // field positions
  localparam int BIT_ARR_CLK_OFF = 4;
  localparam int BIT_MC_CLK_OFF  = 5;
  localparam int BIT_IDLE_EN     = 0;
  localparam int BIT_IDLE_POL    = 1;
  localparam int CTL_OFF_LSB     = 2;

  // gated control lines: ctl[NUM_CTL-1:0], strobe, byte enable
  localparam int NUM_CTL = 3;
  localparam int GATED_W = NUM_CTL + 2;

  typedef struct packed {
    logic               arr_clk_off;
    logic               mc_clk_off;
    logic               idle_en;
    logic               idle_pol;
    logic [GATED_W-1:0] ctl_off;
  } cfg_t;

endpackage

// File: rtl/pdc_cfg_regs.sv
module pdc_cfg_regs
  import pdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output cfg_t              cfg_o
);

  logic [DATA_W-1:0]   regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] wen;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign wen[r] = wr_i && (addr_i == ADDR_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[r] <= '0;
      end else if (wen[r]) begin
        regs_q[r] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (addr_i == ADDR_W'(r)) begin
        rdata_o = regs_q[r];
      end
    end
  end

  always_comb begin
    cfg_o.arr_clk_off = regs_q[ADDR_CLK][BIT_ARR_CLK_OFF];
    cfg_o.mc_clk_off  = regs_q[ADDR_CLK][BIT_MC_CLK_OFF];
    cfg_o.idle_en     = regs_q[ADDR_IDLE][BIT_IDLE_EN];
    cfg_o.idle_pol    = regs_q[ADDR_IDLE][BIT_IDLE_POL];
    cfg_o.ctl_off     = regs_q[ADDR_CTL][CTL_OFF_LSB +: GATED_W];
  end

endmodule

// File: rtl/pdc_idle_timer.sv
module pdc_idle_timer #(
  parameter int LIMIT = 15,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic en_i,
  input  logic pol_i,
  output logic pwrdn_o
);

  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             strobe_edge, at_idle, cnt_clr, cnt_adv;

  always_comb begin
    strobe_edge = strobe_i ^ prev_q;
    at_idle     = (strobe_i == pol_i);
    cnt_clr     = !en_i || strobe_edge || !at_idle;
    cnt_adv     = !cnt_clr && (cnt_q != LIMIT_C);
    cnt_d       = cnt_q;
    if (cnt_clr) begin
      cnt_d = '0;
    end else if (cnt_adv) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= strobe_i;
      cnt_q  <= cnt_d;
    end
  end

  assign pwrdn_o = (cnt_q == LIMIT_C);

endmodule

// File: rtl/pdc_clk_gate.sv
module pdc_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);

  logic en_lat;

  // enable is captured only while the source clock is low
  always_latch begin
    if (!clk_i) begin
      en_lat = en_i;
    end
  end

  assign clk_o = clk_i & en_lat;

endmodule

// File: rtl/pdc_in_gate.sv
module pdc_in_gate #(
  parameter int W = 5
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] off_i,
  output logic [W-1:0] gated_o
);

  for (genvar i = 0; i < W; i++) begin : g_line
    assign gated_o[i] = raw_i[i] & ~off_i[i];
  end

endmodule

// File: rtl/idle_pwrdn_ctrl.sv
module idle_pwrdn_ctrl
  import pdc_pkg::*;
#(
  parameter int IDLE_LIMIT = 15,
  parameter int NUM_MEM    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe_i,
  input  logic               cs_n_i,
  input  logic [NUM_CTL-1:0] ctl_i,
  input  logic               byte_en_i,
  input  logic               pld_clk_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               pwrdn_o,
  output logic [NUM_MEM-1:0] mem_en_o,
  output logic               arr_clk_o,
  output logic               mcell_clk_o,
  output logic [NUM_CTL-1:0] arr_ctl_o,
  output logic               arr_strobe_o,
  output logic               arr_byte_en_o
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  cfg_t cfg;

  pdc_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  pdc_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .strobe_i (strobe_i),
    .en_i     (cfg.idle_en),
    .pol_i    (cfg.idle_pol),
    .pwrdn_o  (pwrdn_o)
  );

  // memory enables follow chip select only
  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    assign mem_en_o[m] = ~cs_n_i;
  end

  // clock gates: index 0 array, index 1 output registers
  logic [1:0] clk_on, clk_gated;
  assign clk_on = {~cfg.mc_clk_off, ~cfg.arr_clk_off};

  for (genvar g = 0; g < 2; g++) begin : g_cg
    pdc_clk_gate u_cg (
      .clk_i (pld_clk_i),
      .en_i  (clk_on[g]),
      .clk_o (clk_gated[g])
    );
  end
  assign arr_clk_o   = clk_gated[0];
  assign mcell_clk_o = clk_gated[1];

  // control line gating
  logic [GATED_W-1:0] ctl_raw, ctl_gated;
  assign ctl_raw = {byte_en_i, strobe_i, ctl_i};

  pdc_in_gate #(.W(GATED_W)) u_gate (
    .raw_i   (ctl_raw),
    .off_i   (cfg.ctl_off),
    .gated_o (ctl_gated)
  );

  assign arr_ctl_o     = ctl_gated[NUM_CTL-1:0];
  assign arr_strobe_o  = ctl_gated[NUM_CTL];
  assign arr_byte_en_o = ctl_gated[NUM_CTL+1];

endmodule

// File: rtl/idle_pwrdn_ctrl_chk.sv
module idle_pwrdn_ctrl_chk #(
  parameter int NUM_MEM = 3
) (
  input logic               clk,
  input logic               rst_sn,
  input logic               strobe,
  input logic               idle_en,
  input logic               idle_pol,
  input logic               pwrdn,
  input logic               cs_n,
  input logic [NUM_MEM-1:0] mem_en,
  input logic [1:0]         rd_addr,
  input logic [7:0]         rd_data
);

  a_r2_off_no_pwrdn: assert property (@(posedge clk) disable iff (!rst_sn)
    !idle_en |=> !pwrdn);

  a_r3_rise_after_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(pwrdn) |-> ($past(idle_en) && ($past(strobe) == $past(idle_pol))));

  a_r4_change_clears: assert property (@(posedge clk) disable iff (!rst_sn)
    (idle_en && (strobe != $past(strobe))) |=> !pwrdn);

  a_r5_holds_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    (pwrdn && idle_en && (strobe == idle_pol) && $stable(strobe)) |=> pwrdn);

  a_r6_mem_off: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_n |-> (mem_en == '0));

  a_r6_mem_on: assert property (@(posedge clk) disable iff (!rst_sn)
    !cs_n |-> (&mem_en));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_addr == 2'd3) |-> (rd_data == 8'h00));

endmodule

bind idle_pwrdn_ctrl idle_pwrdn_ctrl_chk #(.NUM_MEM(NUM_MEM)) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sync_n),
  .strobe   (strobe_i),
  .idle_en  (cfg.idle_en),
  .idle_pol (cfg.idle_pol),
  .pwrdn    (pwrdn_o),
  .cs_n     (cs_n_i),
  .mem_en   (mem_en_o),
  .rd_addr  (reg_addr_i),
  .rd_data  (reg_rdata_o)
);

// File: tb/idle_pwrdn_ctrl_tb.sv
module idle_pwrdn_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe, cs_n, byte_en, pld_clk, reg_wr;
  logic [2:0] ctl;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       pwrdn, arr_clk, mcell_clk, arr_strobe, arr_be;
  logic [2:0] mem_en, arr_ctl;

  always #5 clk = ~clk;

  idle_pwrdn_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .cs_n_i(cs_n),
    .ctl_i(ctl), .byte_en_i(byte_en), .pld_clk_i(pld_clk),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .pwrdn_o(pwrdn), .mem_en_o(mem_en),
    .arr_clk_o(arr_clk), .mcell_clk_o(mcell_clk), .arr_ctl_o(arr_ctl),
    .arr_strobe_o(arr_strobe), .arr_byte_en_o(arr_be)
  );

  // reference model state
  int         n_cmp = 0;
  int         n_bad = 0;
  int         m_cnt = 0;
  logic       m_prev = 1'b0;
  logic [7:0] m_reg [4];
  logic       m_on_a = 1'b1, m_on_m = 1'b1;
  bit         clk_run = 0;
  int         clk_div = 0;
  string      cur_req = "R1";

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic follow_latch();
    if (!pld_clk) begin
      m_on_a = !m_reg[0][4];
      m_on_m = !m_reg[0][5];
    end
  endtask

  task automatic compare();
    logic [4:0] raw;
    raw = {byte_en, strobe, ctl};
    chk(cur_req, "pwrdn", 32'(pwrdn), 32'(m_cnt == 15));
    chk("R6", "mem_en", 32'(mem_en), cs_n ? 32'h0 : 32'h7);
    chk("R8", "arr_ctl", 32'({arr_be, arr_strobe, arr_ctl}), 32'(raw & ~m_reg[2][6:2]));
    chk("R7", "arr_clk", 32'(arr_clk), 32'(pld_clk & m_on_a));
    chk("R7", "mcell_clk", 32'(mcell_clk), 32'(pld_clk & m_on_m));
    chk("R9", "rdata", 32'(reg_rdata), (reg_addr == 2'd3) ? 32'h0 : 32'(m_reg[reg_addr]));
  endtask

  task automatic tick();
    @(posedge clk);
    if (m_reg[1][0]) begin
      if ((strobe != m_prev) || (strobe != m_reg[1][1])) m_cnt = 0;
      else if (m_cnt < 15) m_cnt++;
    end else begin
      m_cnt = 0;
    end
    m_prev = strobe;
    if (reg_wr && reg_addr != 2'd3) m_reg[reg_addr] = reg_wdata;
    follow_latch();
    @(negedge clk);
    compare();
    if (clk_run) begin
      clk_div++;
      if (clk_div == 3) begin
        clk_div = 0;
        pld_clk = !pld_clk;
      end
    end
    follow_latch();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    rst_n = 1'b0; strobe = 1'b0; cs_n = 1'b1; byte_en = 1'b0; pld_clk = 1'b0;
    reg_wr = 1'b0; ctl = 3'b000; reg_addr = 2'd0; reg_wdata = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ticks(4);

    // R1: reset state of the window and the power-down output
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1;
      chk("R1", "reset readback", 32'(reg_rdata), 32'h0);
    end
    chk("R1", "reset pwrdn", 32'(pwrdn), 32'h0);

    // R2: counting disabled, strobe held at both levels
    cur_req = "R2";
    ticks(30);
    strobe = 1'b1;
    ticks(20);

    // R3: idle level 1, saturate
    cur_req = "R3";
    wr(2'd1, 8'h03);
    ticks(14);
    chk("R3", "pwrdn not yet", 32'(pwrdn), 32'h0);
    ticks(6);
    chk("R3", "pwrdn after idle", 32'(pwrdn), 32'h1);

    // R5: one-clock glitch drops it, then recount
    cur_req = "R5";
    strobe = 1'b0; tick();
    strobe = 1'b1;
    ticks(20);

    // R4: toggling strobe with chip select moving
    cur_req = "R4";
    for (int i = 0; i < 80; i++) begin
      if (i % 4 == 0) strobe = !strobe;
      cs_n = (i % 7) < 3;
      tick();
    end
    cs_n = 1'b0;

    // R3: idle level 0
    cur_req = "R3";
    wr(2'd1, 8'h01);
    strobe = 1'b0;
    ticks(20);
    // R4: leave idle level for a few clocks
    cur_req = "R4";
    strobe = 1'b1; ticks(3);
    strobe = 1'b0; ticks(18);
    // R5: disable while asserted
    cur_req = "R5";
    wr(2'd1, 8'h00);
    ticks(5);

    // R7: clock gates with a running source clock
    cur_req = "R7";
    clk_run = 1;
    wr(2'd0, 8'h10); ticks(10);
    wr(2'd0, 8'h20); ticks(11);
    wr(2'd0, 8'h30); ticks(10);
    wr(2'd0, 8'hCF); ticks(13);

    // R8: every gate pattern against several input patterns
    cur_req = "R8";
    for (int p = 0; p < 32; p++) begin
      wr(2'd2, {1'b1, 5'(p), 2'b10});
      {byte_en, strobe, ctl} = 5'b11111; tick();
      {byte_en, strobe, ctl} = 5'b10101; tick();
      {byte_en, strobe, ctl} = 5'b01010; tick();
    end

    // R9: writes to the unmapped address change nothing
    cur_req = "R9";
    wr(2'd1, 8'hA4);
    wr(2'd3, 8'hFF);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      tick();
    end
    reg_addr = 2'd1; #1;
    chk("R9", "addr1 readback", 32'(reg_rdata), 32'hA4);
    reg_addr = 2'd3; #1;
    chk("R9", "addr3 reads zero", 32'(reg_rdata), 32'h0);
    ticks(4);

    summary();
  end

endmodule